// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the four shared PCI interrupt request lines (numbered 0 to 3, often called A to D) onto the sixteen inputs of a legacy interrupt controller. Each request line has its own byte-wide route register. Software writes these registers through a byte-addressed configuration write port, and it reads them back through a separate read port that needs no clock. A route value below sixteen sends the line to the controller input with that number. Any larger value turns the route off.

Internally the block keeps a level bitmap with one bit for each pair of controller input and request line. Each controller output is the OR of the four bits in its group, so two lines routed to the same input share it cleanly. A write to any route register clears the whole bitmap and rebuilds it from the request levels present at that moment, using the new routes. A line that has been moved therefore leaves no stale level behind on its old input.

A small combinational helper is also included. It works out which request line a device interrupt pin lands on, using the slot number taken from the device/function byte.

Top module: `pirq_router`

## Requirements
- R1: While reset is asserted, every route register reads back 0x80 and all sixteen controller outputs are low.
- R2: A write strobe with offset 0x60+n (n = request line 0..3) stores the data byte in route register n. Reading that offset returns exactly the byte written.
- R3: A write to any offset outside 0x60..0x63 changes no route register and no output. A read of such an offset returns 0x00.
- R4: When a line's route value r is below 16, controller output r follows the line's request level with one clock of delay.
- R5: A route value of 16 (0x10) or more disables the line, so no output responds to it. A value of 15 still routes.
- R6: An output that several request lines share stays high while any one of those lines is high.
- R7: A route write clears and rebuilds the level bitmap. One clock after the write, the old input of a moved active line drops and its new input is high.
- R8: The device pin helper returns (pin + slot + 3) mod 4, where slot = dev_fn[7:3]. This equals (pin + slot − 1) mod 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write byte offset |
| cfg_wr_data | input | 8 | Configuration write data byte |
| cfg_rd_addr | input | 8 | Configuration read byte offset |
| cfg_rd_data | output | 8 | Read data for the route registers (0x00 elsewhere) |
| req_lvl | input | 4 | Levels of the four shared request lines |
| ctrl_irq | output | 16 | Levels driven to the interrupt controller inputs |
| dev_fn | input | 8 | Device/function number for the pin helper |
| dev_pin | input | 2 | Device interrupt pin (0..3) |
| dev_line | output | 2 | Request line the pin drives |

## Verification
The hardest case to reach is a route rewrite while the moved line is asserted and another line already holds the new target. In that case the rebuild must drop the old input and keep the shared one high in the same cycle. The bench first parks one active line on an input. It then raises a second line elsewhere and moves the second line onto the first line's input. Finally it moves the first line away, checking the outputs one clock after each write. The bench also writes the boundary route values 15, 16 and 0xFF, and writes to offsets just outside the route window, to check that the router ignores them.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned PIRQ_LINES  = 4;
  localparam int unsigned PIRQ_INPUTS = 16;
  localparam logic [7:0]  ROUTE_BASE  = 8'h60;
  localparam logic [7:0]  ROUTE_RST   = 8'h80;
  typedef logic [7:0] cfg_byte_t;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = PIRQ_LINES,
  parameter cfg_byte_t   BASE      = ROUTE_BASE,
  parameter cfg_byte_t   RST_VAL   = ROUTE_RST
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  cfg_byte_t                     wr_addr,
  input  cfg_byte_t                     wr_data,
  input  cfg_byte_t                     rd_addr,
  output cfg_byte_t                     rd_data,
  output logic [NUM_LINES-1:0][7:0]     route_q,
  output logic [NUM_LINES-1:0][7:0]     route_d,
  output logic                          wr_hit
);

  // next-state: the written byte replaces one route
  always_comb begin
    route_d = route_q;
    wr_hit  = 1'b0;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (wr_en && (wr_addr == BASE + 8'(l))) begin
        route_d[l] = wr_data;
        wr_hit     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= {NUM_LINES{RST_VAL}};
    end else if (wr_hit) begin
      route_q <= route_d;
    end
  end

  // readback without a clock; unmapped offsets read zero
  always_comb begin
    rd_data = '0;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (rd_addr == BASE + 8'(l)) rd_data = route_q[l];
    end
  end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = PIRQ_LINES,
  parameter int unsigned NUM_INPUTS = PIRQ_INPUTS,
  localparam int unsigned LVL_W     = NUM_LINES * NUM_INPUTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINES-1:0][7:0] route_d,
  input  logic                      rebuild,
  input  logic [NUM_LINES-1:0]      req_lvl,
  output logic [LVL_W-1:0]          lvl_q
);

  logic [LVL_W-1:0] lvl_d;
  logic             lvl_en;

  // bit index = input * NUM_LINES + line; a rebuild starts from empty
  always_comb begin
    lvl_d = rebuild ? '0 : lvl_q;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (route_d[l] < 8'(NUM_INPUTS)) begin
        lvl_d[int'(route_d[l]) * int'(NUM_LINES) + l] = req_lvl[l];
      end
    end
  end

  assign lvl_en = (lvl_d != lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/pirq_out_merge.sv
module pirq_out_merge
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = PIRQ_LINES,
  parameter int unsigned NUM_INPUTS = PIRQ_INPUTS,
  localparam int unsigned LVL_W     = NUM_LINES * NUM_INPUTS
) (
  input  logic [LVL_W-1:0]      lvl_q,
  output logic [NUM_INPUTS-1:0] irq
);

  for (genvar i = 0; i < int'(NUM_INPUTS); i++) begin : g_in
    assign irq[i] = |lvl_q[i*NUM_LINES +: NUM_LINES];
  end

endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = PIRQ_LINES,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [7:0]        dev_fn,
  input  logic [LINE_W-1:0] dev_pin,
  output logic [LINE_W-1:0] dev_line
);

  int sum;

  // slot minus one, offset by NUM_LINES so the sum never goes negative
  always_comb begin
    sum      = int'(dev_pin) + int'(dev_fn[7:3]) + int'(NUM_LINES) - 1;
    dev_line = LINE_W'(sum % int'(NUM_LINES));
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = PIRQ_LINES,
  parameter int unsigned NUM_INPUTS = PIRQ_INPUTS,
  parameter cfg_byte_t   BASE       = ROUTE_BASE,
  parameter cfg_byte_t   RST_VAL    = ROUTE_RST,
  localparam int unsigned LINE_W    = $clog2(NUM_LINES),
  localparam int unsigned LVL_W     = NUM_LINES * NUM_INPUTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [7:0]            cfg_wr_addr,
  input  logic [7:0]            cfg_wr_data,
  input  logic [7:0]            cfg_rd_addr,
  output logic [7:0]            cfg_rd_data,
  input  logic [NUM_LINES-1:0]  req_lvl,
  output logic [NUM_INPUTS-1:0] ctrl_irq,
  input  logic [7:0]            dev_fn,
  input  logic [LINE_W-1:0]     dev_pin,
  output logic [LINE_W-1:0]     dev_line
);

  logic [NUM_LINES-1:0][7:0] route_q;
  logic [NUM_LINES-1:0][7:0] route_d;
  logic                      route_wr;
  logic [LVL_W-1:0]          lvl_q;

  pirq_route_regs #(
    .NUM_LINES(NUM_LINES), .BASE(BASE), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .rd_addr (cfg_rd_addr),
    .rd_data (cfg_rd_data),
    .route_q (route_q),
    .route_d (route_d),
    .wr_hit  (route_wr)
  );

  pirq_level_map #(
    .NUM_LINES(NUM_LINES), .NUM_INPUTS(NUM_INPUTS)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .route_d (route_d),
    .rebuild (route_wr),
    .req_lvl (req_lvl),
    .lvl_q   (lvl_q)
  );

  pirq_out_merge #(
    .NUM_LINES(NUM_LINES), .NUM_INPUTS(NUM_INPUTS)
  ) u_merge (
    .lvl_q (lvl_q),
    .irq   (ctrl_irq)
  );

  pirq_slot_swizzle #(
    .NUM_LINES(NUM_LINES)
  ) u_swz (
    .dev_fn   (dev_fn),
    .dev_pin  (dev_pin),
    .dev_line (dev_line)
  );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned NUM_LINES  = 4,
  parameter int unsigned NUM_INPUTS = 16,
  parameter logic [7:0]  BASE       = 8'h60,
  parameter logic [7:0]  RST_VAL    = 8'h80
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_wr_en,
  input logic [7:0]                cfg_wr_addr,
  input logic [7:0]                cfg_wr_data,
  input logic [NUM_LINES-1:0]      req_lvl,
  input logic [NUM_INPUTS-1:0]     ctrl_irq,
  input logic [NUM_LINES-1:0][7:0] route_q
);

  logic [NUM_LINES-1:0]  req_prev;
  logic [NUM_INPUTS-1:0] expect_irq;
  logic [NUM_INPUTS-1:0] reach;
  logic                  win_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev <= '0;
    else        req_prev <= req_lvl;
  end

  always_comb begin
    expect_irq = '0;
    reach      = '0;
    for (int i = 0; i < int'(NUM_INPUTS); i++) begin
      for (int l = 0; l < int'(NUM_LINES); l++) begin
        if (int'(route_q[l]) == i) begin
          reach[i] = 1'b1;
          if (req_prev[l]) expect_irq[i] = 1'b1;
        end
      end
    end
  end

  assign win_wr = cfg_wr_en && (cfg_wr_addr >= BASE) &&
                  (int'(cfg_wr_addr) < int'(BASE) + int'(NUM_LINES));

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ctrl_irq == '0 && route_q == {NUM_LINES{RST_VAL}}));

  // R2: a route write stores the byte
  for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_wr
    a_r2_route_store: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_addr == BASE + 8'(g)) |=> route_q[g] == $past(cfg_wr_data));
  end

  // R3: writes outside the window leave the routes alone
  a_r3_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(route_q));

  // R4 / R6 / R7: outputs match the OR of routed levels one clock later
  a_r4_output_model: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_irq == expect_irq);

  // R5: no output is high unless some line is routed to it
  a_r5_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_irq & ~reach) == '0);

endmodule

bind pirq_router pirq_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_INPUTS(NUM_INPUTS), .BASE(BASE), .RST_VAL(RST_VAL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_addr (cfg_wr_addr),
  .cfg_wr_data (cfg_wr_data),
  .req_lvl     (req_lvl),
  .ctrl_irq    (ctrl_irq),
  .route_q     (route_q)
);

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic [7:0]  cfg_rd_addr = '0;
  logic [7:0]  cfg_rd_data;
  logic [3:0]  req_lvl = '0;
  logic [15:0] ctrl_irq;
  logic [7:0]  dev_fn = '0;
  logic [1:0]  dev_pin = '0;
  logic [1:0]  dev_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .req_lvl(req_lvl), .ctrl_irq(ctrl_irq),
    .dev_fn(dev_fn), .dev_pin(dev_pin), .dev_line(dev_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_rd_addr = a;
    #0.5;
    chk(req, {24'h0, cfg_rd_data}, {24'h0, exp});
  endtask

  task automatic t_reset();
    for (int l = 0; l < 4; l++) rd_chk("R1 reset route", 8'h60 + 8'(l), 8'h80);
    chk("R1 reset outputs", {16'h0, ctrl_irq}, 32'h0);
    req_lvl = 4'hF;
    tick();
    chk("R5 disabled after reset", {16'h0, ctrl_irq}, 32'h0);
    req_lvl = 4'h0;
    tick();
  endtask

  task automatic t_basic();
    wr(8'h60, 8'h05);
    rd_chk("R2 readback line 0", 8'h60, 8'h05);
    req_lvl[0] = 1'b1;
    #0.5;
    chk("R4 no change before edge", {16'h0, ctrl_irq}, 32'h0);
    tick();
    chk("R4 rise one clock later", {16'h0, ctrl_irq}, 32'h0020);
    req_lvl[0] = 1'b0;
    tick();
    chk("R4 fall one clock later", {16'h0, ctrl_irq}, 32'h0);
  endtask

  task automatic t_boundary();
    wr(8'h61, 8'h0F);
    req_lvl[1] = 1'b1;
    tick();
    chk("R5 value 15 routes", {16'h0, ctrl_irq}, 32'h8000);
    wr(8'h61, 8'h10);
    rd_chk("R2 readback 0x10", 8'h61, 8'h10);
    chk("R5 value 16 disables", {16'h0, ctrl_irq}, 32'h0);
    wr(8'h61, 8'hFF);
    tick();
    chk("R5 value 0xFF disables", {16'h0, ctrl_irq}, 32'h0);
    rd_chk("R2 readback 0xFF", 8'h61, 8'hFF);
    req_lvl[1] = 1'b0;
    tick();
  endtask

  task automatic t_share();
    wr(8'h60, 8'h03);
    wr(8'h62, 8'h03);
    req_lvl = 4'b0101;
    tick();
    chk("R6 both high", {16'h0, ctrl_irq}, 32'h0008);
    req_lvl = 4'b0100;
    tick();
    chk("R6 one of two high", {16'h0, ctrl_irq}, 32'h0008);
    req_lvl = 4'b0000;
    tick();
    chk("R6 none high", {16'h0, ctrl_irq}, 32'h0);
  endtask

  task automatic t_reroute();
    wr(8'h60, 8'h05);
    wr(8'h63, 8'h02);
    req_lvl = 4'b1001;
    tick();
    chk("R7 before reroute", {16'h0, ctrl_irq}, 32'h0024);
    wr(8'h63, 8'h05);
    chk("R7 move onto shared input", {16'h0, ctrl_irq}, 32'h0020);
    wr(8'h60, 8'h09);
    chk("R7 move away from shared input", {16'h0, ctrl_irq}, 32'h0220);
    wr(8'h60, 8'h80);
    chk("R7 disable active line", {16'h0, ctrl_irq}, 32'h0020);
    req_lvl = 4'b0000;
    tick();
    chk("R7 all low", {16'h0, ctrl_irq}, 32'h0);
  endtask

  task automatic t_ignore();
    wr(8'h62, 8'h07);
    req_lvl[2] = 1'b1;
    tick();
    wr(8'h64, 8'h01);
    wr(8'h5F, 8'h01);
    wr(8'hE2, 8'h01);
    rd_chk("R3 route 0 kept", 8'h60, 8'h80);
    rd_chk("R3 route 2 kept", 8'h62, 8'h07);
    rd_chk("R3 route 3 kept", 8'h63, 8'h05);
    chk("R3 outputs kept", {16'h0, ctrl_irq}, 32'h0080);
    rd_chk("R3 unmapped read", 8'h64, 8'h00);
    req_lvl = 4'b0000;
    tick();
  endtask

  task automatic t_swizzle();
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        dev_fn  = {5'(s), 3'(p + s)};
        dev_pin = 2'(p);
        #0.5;
        chk("R8 swizzle", {30'h0, dev_line}, 32'((p + s + 3) % 4));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_hold();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_boundary();
    t_share();
    t_reroute();
    t_ignore();
    t_swizzle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic t_reset_hold();
    req_lvl = 4'hF;
    #0.5;
    chk("R1 outputs low in reset", {16'h0, ctrl_irq}, 32'h0);
    rd_chk("R1 route in reset", 8'h63, 8'h80);
    req_lvl = 4'h0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule